// File: doc/BRIEF.md
# Flash Converter Thermometer Decode Back End

This block is the digital end of a 64-comparator flash converter. Each conversion cycle it takes a snapshot of the comparator outputs into a latch stage. It reduces that snapshot to a 7-bit result: a six-bit data field plus an overflow flag. On the opposite clock edge it loads the result into an output register. A comparator reads low when its reference tap sits below the analog input, so the result is the number of comparators that read low.

A polarity input picks which half of the clock period is the sampling half, which lets the block line up with either clock phase of the surrounding system. The output drivers are modelled as two enable flags. One input turns off only the six data bits. The other turns off the data bits and the overflow bit together. The analog front end is not part of this block.

Top module: `flash_decode_backend`

## Requirements
- R1: The stored result equals the number of comparator inputs that were low when the latch captured them. `data_o[5:0]` holds the binary count with bit 0 as its least significant bit, and `ovf_o` is bit 6 of the same count.
- R2: Patterns that are not a clean thermometer (isolated highs among lows, or the reverse) give the plain count of low inputs, with no search for a transition.
- R3: When all 64 inputs are low, `ovf_o` is 1 and `data_o` is 0. When `ovf_o` is 1, `data_o` is always 0.
- R4: With `clk_pol_i` high, comparator states are captured on the falling edge of `clk`. A change on `comp_i` after that falling edge does not affect the result loaded on the following rising edge.
- R5: With `clk_pol_i` high, the captured result appears on the outputs right after the next rising edge of `clk`. One new result arrives every clock cycle.
- R6: With `clk_pol_i` low, the internal clock is the complement of `clk`. Capture then happens on the rising edge of `clk` and loading on the falling edge.
- R7: While `data_off_i` is high, `data_oe_o` is 0 and `ovf_oe_o` follows `bus_on_i` alone.
- R8: While `bus_on_i` is low, both `data_oe_o` and `ovf_oe_o` are 0.
- R9: With `data_off_i` low and `bus_on_i` high, both enable flags are 1.
- R10: `rst` is synchronous and active high. It clears the latch stage on internal capture edges and the output register on internal load edges, so the outputs are 0 while it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_pol_i | input | 1 | 1: sample in clk high half; 0: clock complemented |
| data_off_i | input | 1 | High turns off the data bit drivers |
| bus_on_i | input | 1 | Low turns off the data and overflow drivers |
| comp_i | input | 64 | Raw comparator outputs, low means tap below input |
| data_o | output | 6 | Registered data bits of the count |
| ovf_o | output | 1 | Registered overflow bit (count of 64) |
| data_oe_o | output | 1 | Enable for the six data bit drivers |
| ovf_oe_o | output | 1 | Enable for the overflow bit driver |

## Verification
The first capture edge after a fault decides what shows up at the ports. A wrong snapshot in the latch stage or a wrong group count becomes a wrong value on `data_o`/`ovf_o` exactly one internal load edge later. Capturing on the wrong edge shows when the input changes between the two edges: the stale or the early pattern reaches the outputs in that same cycle. Enable faults are purely combinational and appear at once on `data_oe_o`/`ovf_oe_o`.

// File: rtl/fdec_pkg.sv
package fdec_pkg;

    parameter int NUM_COMP   = 64;
    parameter int GROUP_W    = 8;

    localparam int CODE_W     = $clog2(NUM_COMP + 1);
    localparam int DATA_W     = CODE_W - 1;
    localparam int NUM_GROUPS = NUM_COMP / GROUP_W;
    localparam int GCNT_W     = $clog2(GROUP_W + 1);

    typedef logic [NUM_COMP-1:0] therm_t;

    // Result word: overflow flag above the data field.
    typedef struct packed {
        logic              ovf;
        logic [DATA_W-1:0] data;
    } code_t;

    typedef struct packed {
        logic data_en;
        logic ovf_en;
    } oe_t;

    // Number of low bits within one comparator group.
    function automatic logic [GCNT_W-1:0] group_lows(input logic [GROUP_W-1:0] g);
        logic [GCNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < GROUP_W; i++) begin
            n = n + GCNT_W'(~g[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/fdec_capture.sv
module fdec_capture
    import fdec_pkg::*;
(
    input  logic   iclk,
    input  logic   rst,
    input  therm_t comp_d,
    output therm_t comp_q
);
    // Sampling ends on the falling edge of the internal clock.
    always_ff @(negedge iclk) begin
        if (rst) comp_q <= '0;
        else     comp_q <= comp_d;
    end
endmodule

// File: rtl/fdec_encoder.sv
module fdec_encoder
    import fdec_pkg::*;
(
    input  therm_t comp,
    output code_t  code
);
    logic [GCNT_W-1:0] gcnt [NUM_GROUPS];

    // One low-counter per comparator group.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign gcnt[g] = group_lows(comp[g*GROUP_W +: GROUP_W]);
    end

    logic [CODE_W-1:0] total;
    always_comb begin
        total = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            total = total + CODE_W'(gcnt[g]);
        end
    end

    assign code = code_t'(total);
endmodule

// File: rtl/fdec_outreg.sv
module fdec_outreg
    import fdec_pkg::*;
(
    input  logic  iclk,
    input  logic  rst,
    input  code_t code_d,
    output code_t code_q
);
    // Result is loaded on the rising edge that opens the next sample phase.
    always_ff @(posedge iclk) begin
        if (rst) code_q <= '0;
        else     code_q <= code_d;
    end
endmodule

// File: rtl/fdec_oe.sv
module fdec_oe
    import fdec_pkg::*;
(
    input  logic data_off,
    input  logic bus_on,
    output oe_t  oe
);
    always_comb begin
        oe.ovf_en  = bus_on;
        oe.data_en = bus_on & ~data_off;
    end
endmodule

// File: rtl/flash_decode_backend.sv
module flash_decode_backend
    import fdec_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clk_pol_i,
    input  logic                data_off_i,
    input  logic                bus_on_i,
    input  logic [NUM_COMP-1:0] comp_i,
    output logic [DATA_W-1:0]   data_o,
    output logic                ovf_o,
    output logic                data_oe_o,
    output logic                ovf_oe_o
);
    logic   iclk;
    therm_t comp_lat;
    code_t  code_next;
    code_t  code_reg;
    oe_t    oe;

    // Polarity select: low complements the incoming clock.
    assign iclk = clk_pol_i ? clk : ~clk;

    fdec_capture u_cap (
        .iclk   (iclk),
        .rst    (rst),
        .comp_d (comp_i),
        .comp_q (comp_lat)
    );

    fdec_encoder u_enc (
        .comp (comp_lat),
        .code (code_next)
    );

    fdec_outreg u_reg (
        .iclk   (iclk),
        .rst    (rst),
        .code_d (code_next),
        .code_q (code_reg)
    );

    fdec_oe u_oe (
        .data_off (data_off_i),
        .bus_on   (bus_on_i),
        .oe       (oe)
    );

    assign data_o    = code_reg.data;
    assign ovf_o     = code_reg.ovf;
    assign data_oe_o = oe.data_en;
    assign ovf_oe_o  = oe.ovf_en;
endmodule

// File: rtl/fdec_checker.sv
module fdec_checker
    import fdec_pkg::*;
(
    input logic              clk,
    input logic              iclk,
    input logic              rst,
    input logic              data_off_i,
    input logic              bus_on_i,
    input logic [DATA_W-1:0] data_o,
    input logic              ovf_o,
    input logic              data_oe_o,
    input logic              ovf_oe_o
);
    // R3: overflow carries a zero data field
    p_ovf_zero_data_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> (data_o == '0));

    // R7: data drivers off while data_off_i is high
    p_data_off_r7: assert property (@(posedge clk) disable iff (rst)
        data_off_i |-> !data_oe_o);

    // R8: everything off while bus_on_i is low
    p_bus_off_r8: assert property (@(posedge clk) disable iff (rst)
        !bus_on_i |-> (!data_oe_o && !ovf_oe_o));

    // R9: both enabled in the active combination
    p_both_on_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_on_i && !data_off_i) |-> (data_oe_o && ovf_oe_o));

    // R10: a load edge that saw reset leaves a zero result
    p_reset_clear_r10: assert property (@(posedge iclk) disable iff (rst)
        $past(rst) |-> (data_o == '0 && !ovf_o));
endmodule

bind flash_decode_backend fdec_checker u_chk (
    .clk        (clk),
    .iclk       (iclk),
    .rst        (rst),
    .data_off_i (data_off_i),
    .bus_on_i   (bus_on_i),
    .data_o     (data_o),
    .ovf_o      (ovf_o),
    .data_oe_o  (data_oe_o),
    .ovf_oe_o   (ovf_oe_o)
);

// File: tb/flash_decode_backend_test.sv
module flash_decode_backend_test;
    import fdec_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                clk_pol_i = 1'b1;
    logic                data_off_i = 1'b0;
    logic                bus_on_i = 1'b1;
    logic [NUM_COMP-1:0] comp_i = '0;
    logic [DATA_W-1:0]   data_o;
    logic                ovf_o;
    logic                data_oe_o;
    logic                ovf_oe_o;

    int compared = 0;
    int mismatched = 0;

    always #10 clk = ~clk;

    flash_decode_backend uut (
        .clk        (clk),
        .rst        (rst),
        .clk_pol_i  (clk_pol_i),
        .data_off_i (data_off_i),
        .bus_on_i   (bus_on_i),
        .comp_i     (comp_i),
        .data_o     (data_o),
        .ovf_o      (ovf_o),
        .data_oe_o  (data_oe_o),
        .ovf_oe_o   (ovf_oe_o)
    );

    function automatic logic [CODE_W-1:0] exp_code(input logic [NUM_COMP-1:0] v);
        int n = 0;
        for (int i = 0; i < NUM_COMP; i++) if (!v[i]) n++;
        return CODE_W'(n);
    endfunction

    function automatic logic [NUM_COMP-1:0] rand_vec();
        return {$urandom(), $urandom()};
    endfunction

    task automatic check(input string req, input logic [CODE_W-1:0] got,
                         input logic [CODE_W-1:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // One vector through the pipeline, sampling after the internal load edge.
    task automatic convert(input string req, input logic [NUM_COMP-1:0] v);
        if (clk_pol_i) @(posedge clk); else @(negedge clk);
        #2 comp_i = v;
        if (clk_pol_i) @(posedge clk); else @(negedge clk);
        #2 check(req, {ovf_o, data_o}, exp_code(v));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        comp_i = '0;
        repeat (3) @(posedge clk);
        #5 check("R10 reset clears outputs", {ovf_o, data_o}, '0);
        @(posedge clk);
        #2 rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        convert("R1 all high gives zero", '1);
        convert("R3 all low gives overflow", '0);
        for (int k = 1; k < NUM_COMP; k += 9)
            convert("R1 thermometer count", {NUM_COMP{1'b1}} << k);
        convert("R1 count 63", 64'h8000_0000_0000_0000);
        convert("R2 isolated bubbles", 64'hF0F0_0000_FFFF_0001);
        convert("R2 alternating", 64'h5555_5555_5555_5555);

        // R4: change after the falling edge must not reach the result
        @(posedge clk);
        #2 comp_i = 64'hFFFF_FFFF_0000_0000;
        @(negedge clk);
        #2 comp_i = '1;
        @(posedge clk);
        #2 check("R4 capture on falling edge", {ovf_o, data_o}, 7'd32);

        // R2/R5: back-to-back random patterns, one result per cycle
        begin
            logic [NUM_COMP-1:0] prev;
            @(posedge clk);
            #2 prev = rand_vec();
            comp_i = prev;
            for (int i = 0; i < 40; i++) begin
                logic [NUM_COMP-1:0] nxt;
                @(posedge clk);
                #2 check("R5 one result per cycle (R2 random)", {ovf_o, data_o}, exp_code(prev));
                nxt = rand_vec();
                comp_i = nxt;
                prev = nxt;
            end
        end

        // R6: complemented clock
        @(posedge clk);
        #2 clk_pol_i = 1'b0;
        do_reset();
        convert("R6 inverted polarity all low", '0);
        for (int i = 0; i < 10; i++) convert("R6 inverted polarity random", rand_vec());
        @(negedge clk);
        #2 comp_i = 64'h0000_0000_0000_FFFF;
        @(posedge clk);
        #2 comp_i = '0;
        @(negedge clk);
        #2 check("R6 capture on rising edge", {ovf_o, data_o}, 7'd48);

        // R7/R8/R9: enable flags
        for (int c = 0; c < 4; c++) begin
            data_off_i = c[0];
            bus_on_i   = c[1];
            #1;
            if (!bus_on_i)
                check("R8 bus off", {5'd0, data_oe_o, ovf_oe_o}, 7'd0);
            else if (data_off_i)
                check("R7 data off only", {5'd0, data_oe_o, ovf_oe_o}, 7'd1);
            else
                check("R9 both on", {5'd0, data_oe_o, ovf_oe_o}, 7'd3);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule